// File: doc/BRIEF.md
# Mode-Selectable Power Rate Generator

This block converts a signed, already low-pass-filtered power word into streams of single-cycle rate ticks on two paths. The slow path drives a pulse counter or stepper stage downstream. The fast path runs at a fixed multiple of the slow rate and is used for calibration. Each path is a phase accumulator that is clocked by the master clock. The accumulator adds a step proportional to the requested rate on every cycle and emits a tick when it wraps.

A three-bit mode word selects three things: the full-scale base rate, whether the power word maps as sign-and-magnitude about a centre rate or as magnitude only, and the fast-path multiplier. In two of the signed modes the fast path follows a raw channel sample instead of the product, while the slow path keeps reporting power. The power word and the channel samples are sampled on every clock. There is no valid/ready handshake and no back-pressure, because the block always accepts whatever value is present. Words are Q1.(SAMPLE_W-1), where the most negative code is -1.0.

The divider exponent DIV_EXP is a parameter so that simulations can scale the base rate down. It must be at least 8 so that a path can never wrap twice in one cycle.

Top module: `pfc_rate_gen`

## Requirements
- R1: The mode word `mode_sel` holds three control bits. Bit 2 is the frequency-select bit (FS) and is the most significant. Together the bits give modes 0 to 7.
- R2: The base full-scale rate FMAX is f_clk / 2^DIV_EXP when bit 2 is 0, and f_clk / 2^(DIV_EXP-1) when bit 2 is 1.
- R3: In modes 0, 3, 4 and 7, the slow-path rate is FMAX·(1 + k), where k = power_k / 2^(SAMPLE_W-1) is signed. Zero power gives exactly FMAX, and k = -1.0 gives no slow ticks.
- R4: In modes 1, 2, 5 and 6, the slow-path rate is FMAX·|k|. Zero power gives no ticks, and a negative k gives the same rate as the positive k of equal size.
- R5: The fast-path rate is the slow-path rate times 16, 8, 16, 32, 16, 16, 32 and 16 for modes 0 to 7 respectively.
- R6: In mode 3 the fast path runs at 32·FMAX·(1 + x1), where x1 is the channel-1 sample as a Q1 fraction. In mode 7 it runs at 16·FMAX·(1 + x2), using the channel-2 sample. In both modes the slow path still follows power.
- R7: Each path holds an accumulator of DIV_EXP+SAMPLE_W-1 bits that starts at zero after reset. Every clock it adds the path's step, and a tick appears in the cycle after each wrap. Over N cycles with a constant step S, the tick count is floor(N·S / 2^(DIV_EXP+SAMPLE_W-1)).
- R8: A change of mode or input takes effect on the next clock edge and does not clear either accumulator. The phase carries across the change.
- R9: Reset (`rst_n` low, asynchronous) clears both accumulators and holds both ticks low. A tick is never high for two cycles in a row.
- R10: Outside modes 3 and 7, the channel samples have no effect on either tick stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Operating mode; bit 2 selects the base rate |
| power_k | input | SAMPLE_W | Signed filtered power word, Q1 format |
| ch1_sample | input | SAMPLE_W | Signed channel-1 sample for mode 3 |
| ch2_sample | input | SAMPLE_W | Signed channel-2 sample for mode 7 |
| lf_tick | output | 1 | Slow-path rate strobe, one cycle wide |
| hf_tick | output | 1 | Fast-path rate strobe, one cycle wide |

## Verification
A corrupted accumulator phase or a wrong step would make the tick count drift away from the exact floor of step times cycles over the accumulator span. This drift shows at the ports within one tick period: 2^DIV_EXP cycles at zero power in a signed mode, and far sooner on the fast path. A decode fault in the mode word shows up as a count that is off by the multiplier ratio, as a missing centre rate, or as channel sensitivity in the wrong mode. Phase that is lost on a mode change shows as one missing or extra tick across the changeover.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  // Which signal the fast path converts.
  typedef enum logic [1:0] {
    SRC_PRODUCT = 2'd0,
    SRC_CH1     = 2'd1,
    SRC_CH2     = 2'd2
  } fast_src_e;

  // Decoded operating point for one mode code.
  typedef struct packed {
    logic      fast_base;   // 1: halved divider (doubles every step)
    logic      signed_map;  // 1: centre rate plus signed offset
    logic [2:0] mult_log2;  // fast-path multiplier as a power of two
    fast_src_e src;         // fast-path source
  } mode_cfg_t;

  localparam int NUM_MODES = 8;
  localparam int SHIFT_W   = 4;

  function automatic mode_cfg_t decode_mode(input logic [2:0] code);
    mode_cfg_t c;
    c.fast_base = code[2];
    c.src       = SRC_PRODUCT;
    unique case (code)
      3'd0: begin c.signed_map = 1'b1; c.mult_log2 = 3'd4; end
      3'd1: begin c.signed_map = 1'b0; c.mult_log2 = 3'd3; end
      3'd2: begin c.signed_map = 1'b0; c.mult_log2 = 3'd4; end
      3'd3: begin c.signed_map = 1'b1; c.mult_log2 = 3'd5; c.src = SRC_CH1; end
      3'd4: begin c.signed_map = 1'b1; c.mult_log2 = 3'd4; end
      3'd5: begin c.signed_map = 1'b0; c.mult_log2 = 3'd4; end
      3'd6: begin c.signed_map = 1'b0; c.mult_log2 = 3'd5; end
      default: begin c.signed_map = 1'b1; c.mult_log2 = 3'd4; c.src = SRC_CH2; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pfc_mode_decode.sv
module pfc_mode_decode
  import pfc_pkg::*;
(
  input  logic [2:0] mode_sel,
  output mode_cfg_t  cfg
);

  always_comb begin
    cfg = decode_mode(mode_sel);
  end

endmodule

// File: rtl/pfc_step_map.sv
module pfc_step_map
  import pfc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 34
) (
  input  mode_cfg_t                    cfg,
  input  logic signed [SAMPLE_W-1:0]   power_k,
  input  logic signed [SAMPLE_W-1:0]   ch1_sample,
  input  logic signed [SAMPLE_W-1:0]   ch2_sample,
  output logic [ACC_W-1:0]             lf_step,
  output logic [ACC_W-1:0]             hf_step
);

  localparam int BASE_W = SAMPLE_W + 1;
  localparam int PAD_W  = ACC_W - BASE_W;

  // Centre-offset value: half scale plus the signed word, i.e. MSB flipped.
  function automatic logic [BASE_W-1:0] centred(input logic [SAMPLE_W-1:0] x);
    return {1'b0, ~x[SAMPLE_W-1], x[SAMPLE_W-2:0]};
  endfunction

  // Magnitude, with the most negative code mapping to exactly full scale.
  function automatic logic [BASE_W-1:0] magnitude(input logic [SAMPLE_W-1:0] x);
    logic [BASE_W-1:0] ext;
    ext = {x[SAMPLE_W-1], x};
    return x[SAMPLE_W-1] ? (~ext + 1'b1) : ext;
  endfunction

  logic [BASE_W-1:0]  slow_base;
  logic [BASE_W-1:0]  fast_base;
  logic [SHIFT_W-1:0] lf_shift;
  logic [SHIFT_W-1:0] hf_shift;

  always_comb begin
    slow_base = cfg.signed_map ? centred(power_k) : magnitude(power_k);
    unique case (cfg.src)
      SRC_CH1: fast_base = centred(ch1_sample);
      SRC_CH2: fast_base = centred(ch2_sample);
      default: fast_base = slow_base;
    endcase
    lf_shift = {{(SHIFT_W-1){1'b0}}, cfg.fast_base};
    hf_shift = {1'b0, cfg.mult_log2} + lf_shift;
    lf_step  = {{PAD_W{1'b0}}, slow_base} << lf_shift;
    hf_step  = {{PAD_W{1'b0}}, fast_base} << hf_shift;
  end

endmodule

// File: rtl/pfc_phase_accum.sv
module pfc_phase_accum #(
  parameter int ACC_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  output logic             tick
);

  logic [ACC_W-1:0] phase;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum = {1'b0, phase} + {1'b0, step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      phase <= sum[ACC_W-1:0];
      tick  <= sum[ACC_W];
    end
  end

endmodule

// File: rtl/pfc_rate_gen.sv
module pfc_rate_gen
  import pfc_pkg::*;
#(
  parameter int DIV_EXP  = 19,
  parameter int SAMPLE_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  mode_sel,
  input  logic signed [SAMPLE_W-1:0]  power_k,
  input  logic signed [SAMPLE_W-1:0]  ch1_sample,
  input  logic signed [SAMPLE_W-1:0]  ch2_sample,
  output logic                        lf_tick,
  output logic                        hf_tick
);

  localparam int ACC_W   = DIV_EXP + SAMPLE_W - 1;
  localparam int N_PATHS = 2;

  mode_cfg_t        cfg;
  logic [ACC_W-1:0] steps [N_PATHS];
  logic [N_PATHS-1:0] ticks;

  pfc_mode_decode u_decode (
    .mode_sel (mode_sel),
    .cfg      (cfg)
  );

  pfc_step_map #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W)
  ) u_map (
    .cfg        (cfg),
    .power_k    (power_k),
    .ch1_sample (ch1_sample),
    .ch2_sample (ch2_sample),
    .lf_step    (steps[0]),
    .hf_step    (steps[1])
  );

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    pfc_phase_accum #(
      .ACC_W (ACC_W)
    ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (steps[p]),
      .tick  (ticks[p])
    );
  end

  assign lf_tick = ticks[0];
  assign hf_tick = ticks[1];

endmodule

// File: rtl/pfc_rate_gen_chk.sv
module pfc_rate_gen_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          mode_sel,
  input logic [SAMPLE_W-1:0] power_k,
  input logic [SAMPLE_W-1:0] ch1_sample,
  input logic                lf_tick,
  input logic                hf_tick
);

  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic mag_mode;
  assign mag_mode = mode_sel[1] ^ mode_sel[0];

  // R9: strobes are one cycle wide
  p_lf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lf_tick |=> !lf_tick);
  p_hf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hf_tick |=> !hf_tick);

  // R4: magnitude mode with zero power is silent on both paths
  p_mag_zero_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_mode && power_k == '0) |=> (!lf_tick && !hf_tick));

  // R3: signed mode at -1.0 gives no slow ticks
  p_signed_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mag_mode && power_k == MOST_NEG) |=> !lf_tick);

  // R6: channel-1 monitor at -1.0 gives no fast ticks
  p_monitor_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd3 && ch1_sample == MOST_NEG) |=> !hf_tick);

endmodule

bind pfc_rate_gen pfc_rate_gen_chk #(
  .SAMPLE_W (SAMPLE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .power_k    (power_k),
  .ch1_sample (ch1_sample),
  .lf_tick    (lf_tick),
  .hf_tick    (hf_tick)
);

// File: tb/pfc_rate_gen_bench.sv
`timescale 1ns/1ps
module pfc_rate_gen_bench;

  localparam int DIV_EXP  = 9;
  localparam int SAMPLE_W = 16;
  localparam int ACC_W    = DIV_EXP + SAMPLE_W - 1;
  localparam int SEG      = 2048;
  localparam int WATCHDOG = 190000;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic [2:0]                 mode_sel = '0;
  logic signed [SAMPLE_W-1:0] power_k = '0;
  logic signed [SAMPLE_W-1:0] ch1_sample = '0;
  logic signed [SAMPLE_W-1:0] ch2_sample = '0;
  logic                       lf_tick;
  logic                       hf_tick;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint ph_lf, ph_hf;
  longint cnt_lf, cnt_hf;
  int     dbl;

  always #2 clk = ~clk;

  pfc_rate_gen #(
    .DIV_EXP  (DIV_EXP),
    .SAMPLE_W (SAMPLE_W)
  ) u_pfc_rate_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .power_k    (power_k),
    .ch1_sample (ch1_sample),
    .ch2_sample (ch2_sample),
    .lf_tick    (lf_tick),
    .hf_tick    (hf_tick)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1/R2/R3/R4: slow step from the requirement formulas
  function automatic longint exp_lf_step(input logic [2:0] m, input int k);
    longint b;
    b = (m[1] ^ m[0]) ? ((k < 0) ? -k : k) : (k + 32768);
    return b << m[2];
  endfunction

  // R5/R6: fast step
  function automatic longint exp_hf_step(input logic [2:0] m, input int k,
                                         input int c1, input int c2);
    longint b, mult;
    case (m)
      3'd1: mult = 8;
      3'd3, 3'd6: mult = 32;
      default: mult = 16;
    endcase
    if (m == 3'd3)      b = c1 + 32768;
    else if (m == 3'd7) b = c2 + 32768;
    else                b = exp_lf_step(m, k) >> m[2];
    return (b * mult) << m[2];
  endfunction

  task automatic run_seg(input logic [2:0] m, input int k, input int c1,
                         input int c2, input int n, input bit fresh);
    string tl, th;
    bit pl, ph;
    if (fresh) begin
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R9 reset lf", longint'(lf_tick), 0);
      check("R9 reset hf", longint'(hf_tick), 0);
      ph_lf = 0; ph_hf = 0; cnt_lf = 0; cnt_hf = 0; dbl = 0;
    end
    mode_sel   = m;
    power_k    = SAMPLE_W'(k);
    ch1_sample = SAMPLE_W'(c1);
    ch2_sample = SAMPLE_W'(c2);
    rst_n      = 1'b1;
    pl = 0; ph = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (lf_tick) cnt_lf++;
      if (hf_tick) cnt_hf++;
      if ((lf_tick && pl) || (hf_tick && ph)) dbl++;
      pl = lf_tick; ph = hf_tick;
    end
    ph_lf += longint'(n) * exp_lf_step(m, k);
    ph_hf += longint'(n) * exp_hf_step(m, k, c1, c2);
    tl = (m[1] ^ m[0]) ? "R4 R7 slow magnitude" : "R3 R7 slow signed";
    th = (m == 3'd3 || m == 3'd7) ? "R6 R7 fast monitor" : "R5 R10 fast product";
    $display("mode %0d k=%0d c1=%0d c2=%0d", m, k, c1, c2);
    check(tl, cnt_lf, ph_lf >>> ACC_W);
    check(th, cnt_hf, ph_hf >>> ACC_W);
    check("R9 single-cycle ticks", dbl, 0);
  endtask

  initial begin
    int kv [6] = '{-32768, -12345, 0, 1, 20000, 32767};
    int cv [4] = '{-32768, -9000, 0, 32767};
    // R1 R2 R3 R4 R5 R10: all modes, several power words, nonzero channels
    for (int m = 0; m < 8; m++) begin
      for (int j = 0; j < 6; j++) begin
        run_seg(3'(m), kv[j], 9999, -7777, SEG, 1'b1);
      end
    end
    // R6: monitor modes across channel values
    for (int j = 0; j < 4; j++) begin
      run_seg(3'd3, 15000, cv[j], 4000, SEG, 1'b1);
      run_seg(3'd7, -15000, 4000, cv[j], SEG, 1'b1);
    end
    // R10: product mode with a different channel pair gives same counts
    run_seg(3'd0, 20000, -32768, 32767, SEG, 1'b1);
    // R8: mode changes without reset keep the phase
    run_seg(3'd1, 20000, 0, 0, 1000, 1'b1);
    run_seg(3'd6, -20000, 0, 0, 1000, 1'b0);
    run_seg(3'd4, 5000, 0, 0, 1000, 1'b0);
    run_seg(3'd3, 5000, -3000, 0, 777, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule